// File: doc/BRIEF.md
# Write-Only Serial Configuration Receiver

This block is the slave side of a two-wire serial bus. It exists only to accept writes that set up a spread-spectrum clock generator, and it never returns read data. It samples the bus clock and data lines with a fast system clock and finds start and stop conditions in that domain. It checks the address byte for an exact match and then passes over two bytes whose values mean nothing to it. The eight data bytes that follow are held in a shadow copy until the frame closes.

Only two of the eight data bytes carry fields. The frequency byte holds the input range, the output range, the hardware/software select and the stop control. The spread byte holds the three modulation-width bits, the two output enables and the spread-off bit. The live configuration changes only at a stop that ends a complete, well-formed frame addressed to this block. Until the first such write, the outputs keep their power-up defaults, so a system that does not use the interface still gets a working configuration.

Top module: `smb_cfg_rx`

## Requirements
- R1: After reset the outputs hold their defaults: in_range_o=01, out_range_o=10, sw_sel_o=0, stop_o=0, mod_width_o=010, ref_oe_o=1, ss_oe_o=1, spread_on_o=1.
- R2: A frame is a start, the address byte 0xD2 (write bit included), two ignored bytes, then data bytes 0 to 7, each byte MSB first. At the stop, data byte 4 sets in_range_o from bits 7:6, out_range_o from bits 5:4, sw_sel_o from bit 3 and stop_o from bit 2.
- R3: At the same stop, data byte 5 sets mod_width_o[2] from bit 7, mod_width_o[1] from bit 6, mod_width_o[0] from bit 0, ref_oe_o from bit 5 and ss_oe_o from bit 4. spread_on_o is the inverse of bit 1.
- R4: When the address byte is anything other than 0xD2, no byte of the frame is acknowledged and no output changes.
- R5: When the address matches, the block pulls SDA low (sda_pull_o=1) through the ninth clock of every byte up to the eleventh, the address byte included. It releases SDA on the falling edge of that clock, or at a start or a stop.
- R6: A stop that comes before all eleven bytes have been received leaves every output unchanged.
- R7: A twelfth or later byte is not acknowledged. The stop that ends such a frame leaves every output unchanged.
- R8: A start in the middle of a frame discards the partial frame and begins a new one. A complete frame that follows it then takes effect at its stop.
- R9: The outputs stay constant while a frame is being received, and they change only in response to the closing stop.
- R10: The command byte, the count byte, data bytes 0 to 3, 6 and 7, and the reserved bits of bytes 4 and 5 (byte 4 bits 1:0, byte 5 bits 3:2) have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line |
| sda_pull_o | output | 1 | 1 pulls SDA low for an acknowledge |
| in_range_o | output | 2 | Input frequency range select |
| out_range_o | output | 2 | Output frequency range select |
| sw_sel_o | output | 1 | 0 hardware, 1 software frequency select |
| stop_o | output | 1 | 1 requests the clock stop function |
| mod_width_o | output | 3 | Modulation width code {MW2, MW1, MW0} |
| ref_oe_o | output | 1 | Enable for the unmodulated reference output |
| ss_oe_o | output | 1 | Enable for the spread output |
| spread_on_o | output | 1 | 1 turns frequency modulation on |

## Verification
A bit counter that is off by one shows up within the same byte: the acknowledge pull lands on the wrong bus clock, and the master sees a missing or misplaced acknowledge. A wrong address compare is visible on the ninth clock of the first byte. A faulty byte index or a faulty shadow capture only shows once the frame closes. Because outputs change only at a stop, every commit error shows up a few system clocks after that stop, either as wrong field values or as a change when none should happen. The bench therefore compares the full output bundle after every stop, and again just before a stop that is held back.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic [1:0] in_range;
    logic [1:0] out_range;
    logic       sw_sel;
    logic       stop;
    logic [2:0] mod_width;
    logic       ref_oe;
    logic       ss_oe;
    logic       spread_off;
  } cfg_t;

  // field extraction from the two meaningful data bytes; reserved bits dropped
  function automatic cfg_t cfg_from_bytes(input logic [BYTE_W-1:0] freq_b,
                                          input logic [BYTE_W-1:0] sprd_b);
    cfg_t c;
    c.in_range   = freq_b[7:6];
    c.out_range  = freq_b[5:4];
    c.sw_sel     = freq_b[3];
    c.stop       = freq_b[2];
    c.mod_width  = {sprd_b[7], sprd_b[6], sprd_b[0]};
    c.ref_oe     = sprd_b[5];
    c.ss_oe      = sprd_b[4];
    c.spread_off = sprd_b[1];
    return c;
  endfunction

  localparam logic [BYTE_W-1:0] FREQ_RST = 8'h60;
  localparam logic [BYTE_W-1:0] SPRD_RST = 8'h70;

endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= {WIDTH{RST_VAL}};
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/smb_bus_cond.sv
module smb_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);

  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  // SDA edges only count as conditions while SCL stays high across both samples
  assign start_o    = scl_s_i & scl_q &  sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q &  sda_s_i;
  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;

endmodule

// File: rtl/smb_frame_rx.sv
module smb_frame_rx
  import smb_cfg_pkg::*;
#(
  parameter logic [BYTE_W-1:0] DEV_ADDR    = 8'hD2,
  parameter int unsigned       SKIP_BYTES  = 2,
  parameter int unsigned       DATA_BYTES  = 8,
  parameter int unsigned       FREQ_BYTE   = 4,
  parameter int unsigned       SPRD_BYTE   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  output logic              ack_o,
  output logic              addr_ok_o,
  output logic              commit_o,
  output logic [BYTE_W-1:0] freq_b_o,
  output logic [BYTE_W-1:0] sprd_b_o
);

  localparam int unsigned TOTAL     = 1 + SKIP_BYTES + DATA_BYTES;
  localparam int unsigned IDX_W     = $clog2(TOTAL + 1);
  localparam int unsigned BIT_W     = $clog2(BYTE_W + 2);
  localparam int unsigned DATA_BASE = 1 + SKIP_BYTES;

  localparam logic [BIT_W-1:0] BIT_ACK  = BIT_W'(BYTE_W);
  localparam logic [BIT_W-1:0] BIT_HOLD = BIT_W'(BYTE_W + 1);
  localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(TOTAL);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(TOTAL - 1);
  localparam logic [IDX_W-1:0] IDX_FREQ = IDX_W'(DATA_BASE + FREQ_BYTE);
  localparam logic [IDX_W-1:0] IDX_SPRD = IDX_W'(DATA_BASE + SPRD_BYTE);

  logic              in_frame_q, addr_ok_q, full_q, overrun_q, ack_q;
  logic [BIT_W-1:0]  bit_cnt_q;
  logic [IDX_W-1:0]  byte_idx_q;
  logic [BYTE_W-1:0] shift_q, freq_q, sprd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      addr_ok_q  <= 1'b0;
      full_q     <= 1'b0;
      overrun_q  <= 1'b0;
      ack_q      <= 1'b0;
      bit_cnt_q  <= '0;
      byte_idx_q <= '0;
      shift_q    <= '0;
      freq_q     <= FREQ_RST;
      sprd_q     <= SPRD_RST;
    end else if (start_i) begin
      in_frame_q <= 1'b1;
      addr_ok_q  <= 1'b0;
      full_q     <= 1'b0;
      overrun_q  <= 1'b0;
      ack_q      <= 1'b0;
      bit_cnt_q  <= '0;
      byte_idx_q <= '0;
    end else if (stop_i) begin
      in_frame_q <= 1'b0;
      ack_q      <= 1'b0;
      bit_cnt_q  <= '0;
    end else if (in_frame_q) begin
      if (scl_rise_i && bit_cnt_q < BIT_ACK) begin
        shift_q   <= {shift_q[BYTE_W-2:0], sda_s_i};
        bit_cnt_q <= bit_cnt_q + 1'b1;
      end else if (scl_fall_i && bit_cnt_q == BIT_ACK) begin
        bit_cnt_q <= BIT_HOLD;
        if (byte_idx_q == '0) begin
          addr_ok_q <= (shift_q == DEV_ADDR);
          ack_q     <= (shift_q == DEV_ADDR);
        end else if (byte_idx_q < IDX_END) begin
          ack_q <= addr_ok_q;
          if (byte_idx_q == IDX_FREQ) freq_q <= shift_q;
          if (byte_idx_q == IDX_SPRD) sprd_q <= shift_q;
          if (byte_idx_q == IDX_LAST) full_q <= 1'b1;
        end else begin
          overrun_q <= 1'b1;
          ack_q     <= 1'b0;
        end
        if (byte_idx_q < IDX_END) byte_idx_q <= byte_idx_q + 1'b1;
      end else if (scl_fall_i && bit_cnt_q == BIT_HOLD) begin
        ack_q     <= 1'b0;
        bit_cnt_q <= '0;
      end
    end
  end

  assign commit_o  = stop_i & in_frame_q & addr_ok_q & full_q & ~overrun_q;
  assign ack_o     = ack_q;
  assign addr_ok_o = addr_ok_q;
  assign freq_b_o  = freq_q;
  assign sprd_b_o  = sprd_q;

endmodule

// File: rtl/smb_cfg_rx.sv
module smb_cfg_rx
  import smb_cfg_pkg::*;
#(
  parameter logic [7:0]  DEV_ADDR    = 8'hD2,
  parameter int unsigned SKIP_BYTES  = 2,
  parameter int unsigned DATA_BYTES  = 8,
  parameter int unsigned FREQ_BYTE   = 4,
  parameter int unsigned SPRD_BYTE   = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  output logic [1:0] in_range_o,
  output logic [1:0] out_range_o,
  output logic       sw_sel_o,
  output logic       stop_o,
  output logic [2:0] mod_width_o,
  output logic       ref_oe_o,
  output logic       ss_oe_o,
  output logic       spread_on_o
);

  logic              scl_s, sda_s;
  logic              start_w, stop_w, scl_rise_w, scl_fall_w;
  logic              ack_w, addr_ok_w, commit_w;
  logic [BYTE_W-1:0] freq_b, sprd_b;
  cfg_t              cfg_q;

  smb_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  smb_bus_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (scl_s),
    .sda_s_i   (sda_s),
    .start_o   (start_w),
    .stop_o    (stop_w),
    .scl_rise_o(scl_rise_w),
    .scl_fall_o(scl_fall_w)
  );

  smb_frame_rx #(
    .DEV_ADDR  (DEV_ADDR),
    .SKIP_BYTES(SKIP_BYTES),
    .DATA_BYTES(DATA_BYTES),
    .FREQ_BYTE (FREQ_BYTE),
    .SPRD_BYTE (SPRD_BYTE)
  ) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sda_s_i   (sda_s),
    .start_i   (start_w),
    .stop_i    (stop_w),
    .scl_rise_i(scl_rise_w),
    .scl_fall_i(scl_fall_w),
    .ack_o     (ack_w),
    .addr_ok_o (addr_ok_w),
    .commit_o  (commit_w),
    .freq_b_o  (freq_b),
    .sprd_b_o  (sprd_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= cfg_from_bytes(FREQ_RST, SPRD_RST);
    else if (commit_w) cfg_q <= cfg_from_bytes(freq_b, sprd_b);
  end

  assign sda_pull_o  = ack_w;
  assign in_range_o  = cfg_q.in_range;
  assign out_range_o = cfg_q.out_range;
  assign sw_sel_o    = cfg_q.sw_sel;
  assign stop_o      = cfg_q.stop;
  assign mod_width_o = cfg_q.mod_width;
  assign ref_oe_o    = cfg_q.ref_oe;
  assign ss_oe_o     = cfg_q.ss_oe;
  assign spread_on_o = ~cfg_q.spread_off;

endmodule

// File: rtl/smb_cfg_rx_chk.sv
module smb_cfg_rx_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sda_pull_o,
  input logic        start_w,
  input logic        stop_w,
  input logic        scl_fall_w,
  input logic        addr_ok_w,
  input logic        commit_w,
  input logic [11:0] cfg_bus
);

  // R4: no acknowledge without a matched address
  p_ack_needs_match_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_pull_o |-> addr_ok_w);

  // R5: pull changes only at an SCL fall or a bus condition
  p_pull_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_fall_w && !start_w && !stop_w) |=> $stable(sda_pull_o));

  // R5: a stop releases the line
  p_stop_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_w |=> !sda_pull_o);

  // R8: a start releases the line
  p_start_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w |=> !sda_pull_o);

  // R9: outputs hold unless a commit happens
  p_cfg_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_w |=> $stable(cfg_bus));

endmodule

bind smb_cfg_rx smb_cfg_rx_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sda_pull_o(sda_pull_o),
  .start_w   (start_w),
  .stop_w    (stop_w),
  .scl_fall_w(scl_fall_w),
  .addr_ok_w (addr_ok_w),
  .commit_w  (commit_w),
  .cfg_bus   ({in_range_o, out_range_o, sw_sel_o, stop_o, mod_width_o,
               ref_oe_o, ss_oe_o, spread_on_o})
);

// File: tb/smb_cfg_rx_tb_top.sv
module smb_cfg_rx_tb_top;

  localparam int H = 6;
  localparam logic [11:0] CFG_DEF = {2'b01, 2'b10, 1'b0, 1'b0, 3'b010, 1'b1, 1'b1, 1'b1};

  // {address, filler, data byte 4, data byte 5}
  localparam logic [31:0] VEC [6] = '{
    32'hD2_00_FC_F3,
    32'hD2_FF_00_00,
    32'hD3_00_FF_FF,
    32'hD2_A5_6B_8D,
    32'h52_3C_00_00,
    32'hD2_5A_90_62
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic sda_pull;
  logic sda_line;
  logic [1:0] in_range, out_range;
  logic sw_sel, stop_b, ref_oe, ss_oe, spread_on;
  logic [2:0] mod_width;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  assign sda_line = sda_drv & ~sda_pull;

  smb_cfg_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .in_range_o(in_range), .out_range_o(out_range),
    .sw_sel_o(sw_sel), .stop_o(stop_b), .mod_width_o(mod_width),
    .ref_oe_o(ref_oe), .ss_oe_o(ss_oe), .spread_on_o(spread_on)
  );

  function automatic logic [11:0] cfg_now();
    return {in_range, out_range, sw_sel, stop_b, mod_width, ref_oe, ss_oe, spread_on};
  endfunction

  function automatic logic [11:0] exp_cfg(input logic [7:0] b4, input logic [7:0] b5);
    return {b4[7:6], b4[5:4], b4[3], b4[2], b5[7], b5[6], b5[0], b5[5], b5[4], ~b5[1]};
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wait_cyc(H);
    scl_drv = 1'b1; wait_cyc(H);
    sda_drv = 1'b0; wait_cyc(H);
    scl_drv = 1'b0; wait_cyc(H);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wait_cyc(H);
    scl_drv = 1'b1; wait_cyc(H);
    sda_drv = 1'b1; wait_cyc(2*H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; wait_cyc(H);
      scl_drv = 1'b1; wait_cyc(H);
      scl_drv = 1'b0;
    end
    sda_drv = 1'b1; wait_cyc(H);
    scl_drv = 1'b1; wait_cyc(H/2);
    acked = ~sda_line;
    wait_cyc(H - H/2);
    scl_drv = 1'b0; wait_cyc(H);
  endtask

  // sends nbytes of a frame; returns the number of acknowledged bytes
  task automatic send_frame(input logic [7:0] addr, input logic [7:0] fill,
                            input logic [7:0] b4, input logic [7:0] b5,
                            input int nbytes, input bit do_stop, output int acks);
    bit a;
    logic [7:0] b;
    acks = 0;
    bus_start();
    for (int i = 0; i < nbytes; i++) begin
      if (i == 0) b = addr;
      else if (i == 1) b = fill;
      else if (i == 2) b = ~fill;
      else if (i == 7) b = b4;
      else if (i == 8) b = b5;
      else b = fill ^ 8'(i);
      send_byte(b, a);
      if (a) acks++;
    end
    if (do_stop) bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [11:0] exp;
    int acks;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    check("R1 reset defaults", 32'(cfg_now()), 32'(CFG_DEF));
    check("R1 no pull after reset", 32'(sda_pull), 32'd0);
    exp = CFG_DEF;

    // R2 R3 R4 R5 R10 vector walk
    for (int v = 0; v < 6; v++) begin
      logic [7:0] ad, fl, b4, b5;
      {ad, fl, b4, b5} = VEC[v];
      send_frame(ad, fl, b4, b5, 11, 1'b1, acks);
      wait_cyc(4);
      if (ad == 8'hD2) exp = exp_cfg(b4, b5);
      check("R2 R3 R4 R10 vector outputs", 32'(cfg_now()), 32'(exp));
      check("R5 R4 vector ack count", 32'(acks), (ad == 8'hD2) ? 32'd11 : 32'd0);
    end

    // R6: stop after a partial frame
    send_frame(8'hD2, 8'h00, 8'hFF, 8'hFF, 8, 1'b1, acks);
    wait_cyc(4);
    check("R6 partial frame ignored", 32'(cfg_now()), 32'(exp));
    check("R5 partial ack count", 32'(acks), 32'd8);

    // R7: a twelfth byte voids the frame
    send_frame(8'hD2, 8'h11, 8'h00, 8'h00, 12, 1'b1, acks);
    wait_cyc(4);
    check("R7 overrun frame ignored", 32'(cfg_now()), 32'(exp));
    check("R7 twelfth byte not acked", 32'(acks), 32'd11);

    // R9: complete frame held back; no change until stop
    send_frame(8'hD2, 8'h00, 8'h40, 8'h32, 11, 1'b0, acks);
    wait_cyc(4);
    check("R9 no change before stop", 32'(cfg_now()), 32'(exp));
    bus_stop();
    wait_cyc(4);
    exp = exp_cfg(8'h40, 8'h32);
    check("R9 change after stop", 32'(cfg_now()), 32'(exp));

    // R8: repeated start mid-frame, then full frame
    send_frame(8'hD2, 8'h00, 8'hFF, 8'hFF, 8, 1'b0, acks);
    send_frame(8'hD2, 8'h77, 8'hA4, 8'hC1, 11, 1'b1, acks);
    wait_cyc(4);
    exp = exp_cfg(8'hA4, 8'hC1);
    check("R8 restart frame committed", 32'(cfg_now()), 32'(exp));
    check("R8 restart ack count", 32'(acks), 32'd11);

    // R8: restart then partial frame leaves outputs alone
    send_frame(8'hD2, 8'h00, 8'h00, 8'h00, 9, 1'b0, acks);
    send_frame(8'hD2, 8'h00, 8'hFF, 8'hFF, 4, 1'b1, acks);
    wait_cyc(4);
    check("R8 restart discards partial", 32'(cfg_now()), 32'(exp));
    check("R5 released after stop", 32'(sda_pull), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule